// File: doc/BRIEF.md
# Trigger-Matched Packet Batching Controller

This block sits after a set of parallel trigger-matching units. Each unit hands over one result word with the trigger number it belongs to. When every unit has delivered a result for the same trigger, the block joins the words into one packet and writes it into a packet queue. The packet always holds unit 0 first, then unit 1, unit 2 and unit 3. If the trigger numbers of a set disagree, the block throws the whole set away.

The output is a valid/ready word stream that feeds a datagram transmitter. The block keeps the stream idle until a full batch of packets is queued (eight by default). It then sends the whole batch back to back and marks the final word of the last packet with a last flag.

An end-of-burst pulse starts a delay counter, which is set in clock cycles. When the counter runs out, the block gives a one-cycle flush pulse. The pulse clears the partial set, the packet queue and any batch in progress. The same pulse is also brought out so the transmit path can clear its own buffers. Because of this, the first data of the next burst never mixes with leftovers from the previous burst.

Top module: `tmb_batcher`

## Requirements
- R1: After reset every unit_ready bit is 1, out_valid is 0, out_last is 0 and flush_o is 0.
- R2: A committed packet is sent as NUNIT words in unit order. The first word is unit 0's data (bits [W-1:0] of unit_data), then unit 1's, and so on, whatever order the units delivered in.
- R3: A set is committed only when all NUNIT trigger tags are equal. A set with any tag mismatch is discarded once all units have delivered, after which every unit_ready is high again and nothing from that set is ever sent.
- R4: out_valid stays 0 while fewer than BATCH packets are queued.
- R5: A batch is exactly BATCH×NUNIT words. out_last is high only on the final word of the BATCH-th packet, and out_valid is 0 after that word while fewer than BATCH packets remain queued.
- R6: After a unit's result is accepted, that unit's unit_ready stays low until its set is committed, discarded or flushed. Other units are not affected.
- R7: flush_o is high for exactly one cycle. It rises in the FLUSH_CYC-th cycle after the clock edge that samples eob_pulse high.
- R8: An eob_pulse that arrives while the delay is running restarts the count, so only one flush follows, FLUSH_CYC cycles after the last pulse.
- R9: While flush_o is high, all unit_ready bits and out_valid are 0. After the flush, partial sets and queued packets are gone, and the next batch holds only packets that were committed after the flush.
- R10: While out_valid is high and out_ready is low, out_data and out_last hold their values until a flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_valid | input | NUNIT | Result offered by each matching unit |
| unit_ready | output | NUNIT | Result slot of each unit is free |
| unit_data | input | NUNIT×W | Result words, unit i in bits [i×W +: W] |
| unit_tag | input | NUNIT×TW | Trigger numbers, unit i in bits [i×TW +: TW] |
| eob_pulse | input | 1 | End-of-burst trigger, one cycle |
| flush_o | output | 1 | One-cycle flush pulse, also for the transmit path |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | W | Output word |
| out_last | output | 1 | Final word of the batch |

## Verification
The hardest state to reach from the ports is a flush that arrives while both a partial set and several committed packets that have not yet been sent are inside the block. From the outside, nothing tells the queued packets apart from fresh ones. To reach this state, the bench commits three packets, leaves one unit's slot filled, and then pulses end-of-burst. After the flush it commits a full batch with recognisable data. The first word sent must come from the new data, and every unit must be ready again right after the pulse. A second case restarts the delay with a repeated end-of-burst pulse, and the bench checks flush_o on every cycle of the restarted window.

// File: rtl/tmb_pkg.sv
package tmb_pkg;
  typedef enum logic {TX_IDLE = 1'b0, TX_SEND = 1'b1} tx_state_e;
endpackage

// File: rtl/tmb_collect.sv
module tmb_collect #(
  parameter int NUNIT = 4,
  parameter int W     = 16,
  parameter int TW    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [NUNIT-1:0]   unit_valid,
  output logic [NUNIT-1:0]   unit_ready,
  input  logic [NUNIT*W-1:0] unit_data,
  input  logic [NUNIT*TW-1:0] unit_tag,
  input  logic               q_full,
  output logic               push,
  output logic [NUNIT*W-1:0] push_data
);
  logic [NUNIT-1:0]    full_q, full_d;
  logic [NUNIT*W-1:0]  data_q, data_d;
  logic [NUNIT*TW-1:0] tag_q, tag_d;
  logic [NUNIT-1:0]    tag_eq;
  logic                all_full, match, drop, clear;

  genvar g;
  generate
    for (g = 0; g < NUNIT; g++) begin : g_slot
      assign unit_ready[g] = ~full_q[g] & ~flush;
      assign tag_eq[g]     = (tag_q[g*TW +: TW] == tag_q[0 +: TW]);
    end
  endgenerate

  assign all_full  = &full_q;
  assign match     = &tag_eq;
  assign push      = all_full & match & ~q_full & ~flush;
  assign drop      = all_full & ~match;
  assign clear     = push | drop;
  assign push_data = data_q;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    tag_d  = tag_q;
    if (flush || clear) begin
      full_d = '0;
    end else begin
      for (int i = 0; i < NUNIT; i++) begin
        if (unit_valid[i] && unit_ready[i]) begin
          full_d[i]          = 1'b1;
          data_d[i*W +: W]   = unit_data[i*W +: W];
          tag_d[i*TW +: TW]  = unit_tag[i*TW +: TW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      data_q <= '0;
      tag_q  <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
      tag_q  <= tag_d;
    end
  end
endmodule

// File: rtl/tmb_pktq.sv
module tmb_pktq #(
  parameter int DW    = 64,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign count   = cnt_q;
  assign head    = mem[rp_q];
  assign do_push = push & ~full;
  assign do_pop  = pop & (cnt_q != '0);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = nxt(wp_q);
      if (do_pop)  rp_d = nxt(rp_q);
      if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp_q] <= push_data;
  end
endmodule

// File: rtl/tmb_batch_tx.sv
module tmb_batch_tx
  import tmb_pkg::*;
#(
  parameter int NUNIT = 4,
  parameter int W     = 16,
  parameter int BATCH = 8,
  parameter int CW    = 5,
  localparam int XW   = (NUNIT > 1) ? $clog2(NUNIT) : 1,
  localparam int BW   = (BATCH > 1) ? $clog2(BATCH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [CW-1:0]      q_count,
  input  logic [NUNIT*W-1:0] head,
  input  logic               out_ready,
  output logic               pop,
  output logic               out_valid,
  output logic [W-1:0]       out_data,
  output logic               out_last
);
  tx_state_e     st_q, st_d;
  logic [XW-1:0] wix_q, wix_d;
  logic [BW-1:0] pkt_q, pkt_d;
  logic          last_word, last_pkt, fire;

  assign last_word = (wix_q == XW'(NUNIT - 1));
  assign last_pkt  = (pkt_q == BW'(BATCH - 1));
  assign out_valid = (st_q == TX_SEND) & ~flush;
  assign out_data  = head[wix_q*W +: W];
  assign out_last  = out_valid & last_word & last_pkt;
  assign fire      = out_valid & out_ready;
  assign pop       = fire & last_word;

  always_comb begin
    st_d  = st_q;
    wix_d = wix_q;
    pkt_d = pkt_q;
    if (flush) begin
      st_d  = TX_IDLE;
      wix_d = '0;
      pkt_d = '0;
    end else if (st_q == TX_IDLE) begin
      if (q_count >= CW'(BATCH)) st_d = TX_SEND;
      wix_d = '0;
      pkt_d = '0;
    end else if (fire) begin
      if (last_word) begin
        wix_d = '0;
        pkt_d = pkt_q + 1'b1;
        if (last_pkt) begin
          st_d  = TX_IDLE;
          pkt_d = '0;
        end
      end else begin
        wix_d = wix_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      wix_q <= '0;
      pkt_q <= '0;
    end else begin
      st_q  <= st_d;
      wix_q <= wix_d;
      pkt_q <= pkt_d;
    end
  end
endmodule

// File: rtl/tmb_flush_timer.sv
module tmb_flush_timer #(
  parameter int unsigned FLUSH_CYC = 50_000_000,
  localparam int TCW = $clog2(FLUSH_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic eob,
  output logic flush
);
  logic           run_q, run_d, fl_q, fl_d;
  logic [TCW-1:0] cnt_q, cnt_d;

  assign flush = fl_q;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    fl_d  = 1'b0;
    if (eob) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      if (cnt_q == TCW'(FLUSH_CYC - 1)) begin
        run_d = 1'b0;
        fl_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      fl_q  <= 1'b0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      fl_q  <= fl_d;
    end
  end
endmodule

// File: rtl/tmb_batcher.sv
module tmb_batcher #(
  parameter int          NUNIT     = 4,
  parameter int          W         = 16,
  parameter int          TW        = 8,
  parameter int          BATCH     = 8,
  parameter int          QDEPTH    = 16,
  parameter int unsigned FLUSH_CYC = 50_000_000,
  localparam int QCW = ((QDEPTH > 1) ? $clog2(QDEPTH) : 1) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUNIT-1:0]    unit_valid,
  output logic [NUNIT-1:0]    unit_ready,
  input  logic [NUNIT*W-1:0]  unit_data,
  input  logic [NUNIT*TW-1:0] unit_tag,
  input  logic                eob_pulse,
  output logic                flush_o,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [W-1:0]        out_data,
  output logic                out_last
);
  logic               flush, push, pop, q_full;
  logic [NUNIT*W-1:0] push_data, head;
  logic [QCW-1:0]     q_count;

  assign flush_o = flush;

  tmb_flush_timer #(.FLUSH_CYC(FLUSH_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .eob(eob_pulse), .flush(flush)
  );

  tmb_collect #(.NUNIT(NUNIT), .W(W), .TW(TW)) u_coll (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .unit_valid(unit_valid), .unit_ready(unit_ready),
    .unit_data(unit_data), .unit_tag(unit_tag),
    .q_full(q_full), .push(push), .push_data(push_data)
  );

  tmb_pktq #(.DW(NUNIT*W), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(push), .push_data(push_data), .pop(pop),
    .head(head), .count(q_count), .full(q_full)
  );

  tmb_batch_tx #(.NUNIT(NUNIT), .W(W), .BATCH(BATCH), .CW(QCW)) u_tx (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .q_count(q_count), .head(head), .out_ready(out_ready),
    .pop(pop), .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );
endmodule

// File: rtl/tmb_batcher_chk.sv
module tmb_batcher_chk #(
  parameter int NUNIT = 4,
  parameter int W     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NUNIT-1:0] unit_valid,
  input logic [NUNIT-1:0] unit_ready,
  input logic             flush_o,
  input logic             out_valid,
  input logic             out_ready,
  input logic [W-1:0]     out_data,
  input logic             out_last
);
  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o); // R7

  AST_FLUSH_BLOCKS_IO: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (unit_ready == '0) && !out_valid); // R9

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (flush_o || (out_valid && $stable(out_data) && $stable(out_last)))); // R10

  genvar g;
  generate
    for (g = 0; g < NUNIT; g++) begin : g_unit
      AST_SLOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_valid[g] && unit_ready[g]) |=> !unit_ready[g]); // R6
    end
  endgenerate
endmodule

bind tmb_batcher tmb_batcher_chk #(.NUNIT(NUNIT), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .unit_valid(unit_valid), .unit_ready(unit_ready),
  .flush_o(flush_o), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last)
);

// File: tb/sim_tmb_batcher.sv
`timescale 1ns/1ps
module sim_tmb_batcher;
  localparam int NU = 4, W = 16, TW = 8, BATCH = 8, FL = 20;

  logic              clk, rst_n;
  logic [NU-1:0]     unit_valid;
  logic [NU-1:0]     unit_ready;
  logic [NU*W-1:0]   unit_data;
  logic [NU*TW-1:0]  unit_tag;
  logic              eob_pulse, flush_o, out_valid, out_ready, out_last;
  logic [W-1:0]      out_data;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_base [BATCH];

  typedef struct packed {
    logic [31:0] tags;
    logic [15:0] base;
    logic        keep;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{tags: 32'h01010101, base: 16'h0100, keep: 1'b1},
    '{tags: 32'h02020202, base: 16'h0200, keep: 1'b1},
    '{tags: 32'h04030303, base: 16'h0300, keep: 1'b0},
    '{tags: 32'h04040404, base: 16'h0400, keep: 1'b1},
    '{tags: 32'h05050905, base: 16'h0500, keep: 1'b0},
    '{tags: 32'h06060606, base: 16'h0600, keep: 1'b1},
    '{tags: 32'h07070707, base: 16'h0700, keep: 1'b1},
    '{tags: 32'h08080808, base: 16'h0800, keep: 1'b1},
    '{tags: 32'h09090909, base: 16'h0900, keep: 1'b1},
    '{tags: 32'h0A0A0A0A, base: 16'h0A00, keep: 1'b1}
  };

  tmb_batcher #(.NUNIT(NU), .W(W), .TW(TW), .BATCH(BATCH), .QDEPTH(16),
                .FLUSH_CYC(FL)) u0 (
    .clk(clk), .rst_n(rst_n), .unit_valid(unit_valid), .unit_ready(unit_ready),
    .unit_data(unit_data), .unit_tag(unit_tag), .eob_pulse(eob_pulse),
    .flush_o(flush_o), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int u, input logic [15:0] d, input logic [7:0] t);
    @(negedge clk);
    unit_valid[u] = 1'b1;
    unit_data[u*W +: W] = d;
    unit_tag[u*TW +: TW] = t;
    while (!unit_ready[u]) @(negedge clk);
    @(negedge clk);
    unit_valid[u] = 1'b0;
  endtask

  task automatic send_set(input logic [31:0] tags, input logic [15:0] base);
    for (int u = NU - 1; u >= 0; u--) put(u, base + 16'(u), tags[u*8 +: 8]);
    repeat (2) @(negedge clk);
  endtask

  task automatic read_batch();
    int guard;
    for (int p = 0; p < BATCH; p++) begin
      for (int u = 0; u < NU; u++) begin
        guard = 0;
        while (!out_valid && guard < 100) begin @(negedge clk); guard++; end
        chk(out_data == exp_base[p] + 16'(u), "R2 word order",
            32'(out_data), 32'(exp_base[p] + 16'(u)));
        chk(out_last == ((p == BATCH - 1) && (u == NU - 1)), "R5 last flag",
            32'(out_last), 32'((p == BATCH - 1) && (u == NU - 1)));
        if (p == 1 && u == 2) begin
          repeat (3) @(negedge clk);
          chk(out_valid && out_data == exp_base[p] + 16'(u), "R10 hold",
              32'(out_data), 32'(exp_base[p] + 16'(u)));
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
      end
    end
    chk(!out_valid, "R5 batch length", 32'(out_valid), 32'd0);
  endtask

  task automatic pulse_eob();
    @(negedge clk); eob_pulse = 1'b1;
    @(negedge clk); eob_pulse = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int kept;
    rst_n = 1'b0; unit_valid = '0; unit_data = '0; unit_tag = '0;
    eob_pulse = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(unit_ready == 4'hF, "R1 ready", 32'(unit_ready), 32'hF);
    chk(!out_valid && !out_last && !flush_o, "R1 outputs",
        {29'd0, out_valid, out_last, flush_o}, 32'd0);

    // table walk: R3 mismatch drop, R4 hold-off
    kept = 0;
    for (int i = 0; i < 10; i++) begin
      send_set(TBL[i].tags, TBL[i].base);
      if (TBL[i].keep) begin exp_base[kept] = TBL[i].base; kept++; end
      else chk(unit_ready == 4'hF, "R3 dropped set frees slots",
               32'(unit_ready), 32'hF);
      if (kept < BATCH)
        chk(!out_valid, "R4 no output before batch", 32'(out_valid), 32'd0);
    end
    read_batch();

    // R6: one unit holds a slot, others free
    put(0, 16'h5500, 8'h50);
    chk(unit_ready == 4'hE, "R6 slot busy", 32'(unit_ready), 32'hE);
    for (int u = 1; u < NU; u++) put(u, 16'h5500 + 16'(u), 8'h50);
    repeat (2) @(negedge clk);
    send_set(32'h51515151, 16'h5600);
    send_set(32'h52525252, 16'h5700);
    put(2, 16'h5802, 8'h58);

    // R7/R9: flush with queued and partial data
    pulse_eob();
    for (int k = 1; k <= FL; k++) begin
      @(negedge clk);
      chk(flush_o == (k == FL), "R7 flush timing", 32'(flush_o), 32'(k == FL));
      if (k == FL)
        chk(unit_ready == 4'h0 && !out_valid, "R9 blocked during flush",
            {27'd0, out_valid, unit_ready}, 32'd0);
    end
    @(negedge clk);
    chk(unit_ready == 4'hF && !flush_o, "R9 partial cleared",
        {27'd0, flush_o, unit_ready}, 32'hF);
    for (int p = 0; p < BATCH; p++) begin
      send_set({4{8'(8'h70 + p)}}, 16'h7000 + 16'(p * 16));
      exp_base[p] = 16'h7000 + 16'(p * 16);
      if (p < BATCH - 1)
        chk(!out_valid, "R9 stale packets gone", 32'(out_valid), 32'd0);
    end
    read_batch();

    // R8: restart of the delay
    pulse_eob();
    repeat (10) @(negedge clk);
    pulse_eob();
    for (int k = 1; k <= FL + 2; k++) begin
      @(negedge clk);
      chk(flush_o == (k == FL), "R8 restarted delay", 32'(flush_o), 32'(k == FL));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule